// File: doc/BRIEF.md
# DMA Event Status and Interrupt Register Unit

This unit collects event strobes from a transmit DMA engine and a receive DMA engine. It holds them in two status words, one per direction, and folds them through an interrupt enable register into a single interrupt line. Software reads and writes the unit through a 32-bit register port with a word address. Error flags are cleared by writing a 1 to them. Writing a 0 leaves a flag alone, so software never needs a read-modify-write to acknowledge.

Each direction also keeps a saturating packet counter inside its status word. Every completed-packet strobe adds one. Every write-1 acknowledge of the packet bit takes one away. The packet bit reads as set for as long as the counter is not zero. Software can therefore acknowledge frames one at a time and will not lose any that arrived while it was busy.

Top module: `dma_evt_irq`

## Requirements
- R1: After reset, both status words, the enable register, the summary register and irq_o are all zero.
- R2: Transmit status at address 0x188 reads: bit 0 packet-done pending, bit 1 underrun, bit 3 bus error, bits 23:16 the transmit packet count. All other bits read 0.
- R3: Receive status at address 0x194 reads: bit 0 packet-received pending, bit 2 overflow, bit 3 bus error, bits 23:16 the receive packet count. All other bits read 0.
- R4: The underrun, overflow and both bus-error flags are set by their strobe and stay set until software writes a 1 to that bit position of their status word. Writing 0 there has no effect.
- R5: Each packet strobe (tx_sent_ev or rx_rcvd_ev) increments that direction's count by one. The count saturates at 255.
- R6: Writing 1 to bit 0 of a status word decrements that direction's count by one. The write has no effect when the count is 0. Bit 0 reads 1 exactly while the count is nonzero.
- R7: When a strobe and a write-1 clear of the same event fall in the same cycle, the strobe wins. A flag stays set, and a count is left unchanged by the increment and decrement together.
- R8: The enable register at 0x198 is read/write and keeps only bits 0, 1, 3, 4, 6 and 7. All other bits read 0.
- R9: The summary register at 0x19C reads as the event vector ANDed with the enable register. The event vector is: bit 0 tx pending, bit 1 underrun, bit 3 tx bus error, bit 4 rx pending, bit 6 overflow, bit 7 rx bus error. Writes to 0x19C have no effect.
- R10: irq_o is the OR of the summary bits. Writing 0 to the enable register drops irq_o from the next cycle.
- R11: Any other address reads 0, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| tx_sent_ev | input | 1 | Transmit packet completed |
| tx_urun_ev | input | 1 | Transmit underrun |
| tx_berr_ev | input | 1 | Transmit bus error |
| rx_rcvd_ev | input | 1 | Receive packet completed |
| rx_ovf_ev | input | 1 | Receive overflow |
| rx_berr_ev | input | 1 | Receive bus error |
| irq_o | output | 1 | Interrupt request |

## Verification
An engine strobe and a software write-1 acknowledge of the same event can fall in one clock cycle. This touches both the sticky error flags and the packet counters, including the counter at its saturation limit. The bench forces this collision in directed steps and also lets it happen often under random stimulus, where strobes and status writes are drawn independently. After every cycle a bench model built from the requirements predicts every readable register and irq_o. The prediction follows the rule that the strobe wins, and the counter is judged both at zero and at 255.

// File: rtl/dma_evt_irq.sv
module dma_evt_irq #(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              tx_sent_ev,
  input  logic              tx_urun_ev,
  input  logic              tx_berr_ev,
  input  logic              rx_rcvd_ev,
  input  logic              rx_ovf_ev,
  input  logic              rx_berr_ev,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_TXS = ADDR_W'('h188);
  localparam logic [ADDR_W-1:0] A_RXS = ADDR_W'('h194);
  localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'('h198);
  localparam logic [ADDR_W-1:0] A_SUM = ADDR_W'('h19C);
  localparam logic [CNT_W-1:0]  CNT_MAX = '1;
  localparam logic [7:0]        EN_VALID = 8'hDB;

  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic             tx_urun, tx_berr, rx_ovf, rx_berr;
  logic [7:0]       mask_q;

  wire wr_tx  = reg_wr && (reg_addr == A_TXS);
  wire wr_rx  = reg_wr && (reg_addr == A_RXS);
  wire wr_msk = reg_wr && (reg_addr == A_MSK);

  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c,
                                                input logic ack, input logic ev);
    logic [CNT_W-1:0] n;
    n = c;
    if (ack && n != '0) n = n - 1'b1;
    if (ev && n != CNT_MAX) n = n + 1'b1;
    return n;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_cnt  <= '0;
      rx_cnt  <= '0;
      tx_urun <= 1'b0;
      tx_berr <= 1'b0;
      rx_ovf  <= 1'b0;
      rx_berr <= 1'b0;
      mask_q  <= '0;
    end else begin
      tx_cnt  <= cnt_step(tx_cnt, wr_tx && reg_wdata[0], tx_sent_ev);
      rx_cnt  <= cnt_step(rx_cnt, wr_rx && reg_wdata[0], rx_rcvd_ev);
      tx_urun <= tx_urun_ev | (tx_urun & ~(wr_tx & reg_wdata[1]));
      tx_berr <= tx_berr_ev | (tx_berr & ~(wr_tx & reg_wdata[3]));
      rx_ovf  <= rx_ovf_ev  | (rx_ovf  & ~(wr_rx & reg_wdata[2]));
      rx_berr <= rx_berr_ev | (rx_berr & ~(wr_rx & reg_wdata[3]));
      if (wr_msk) mask_q <= reg_wdata[7:0] & EN_VALID;
    end
  end

  wire       tx_pend = |tx_cnt;
  wire       rx_pend = |rx_cnt;
  wire [7:0] evt  = {rx_berr, rx_ovf, 1'b0, rx_pend, tx_berr, 1'b0, tx_urun, tx_pend};
  wire [7:0] summ = evt & mask_q;

  assign irq_o = |summ;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_TXS: reg_rdata = {8'd0, 8'(tx_cnt), 12'd0, tx_berr, 1'b0, tx_urun, tx_pend};
      A_RXS: reg_rdata = {8'd0, 8'(rx_cnt), 12'd0, rx_berr, rx_ovf, 1'b0, rx_pend};
      A_MSK: reg_rdata = {24'd0, mask_q};
      A_SUM: reg_rdata = {24'd0, summ};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_evt_irq_chk.sv
module dma_evt_irq_chk #(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              tx_urun_ev,
  input logic              rx_rcvd_ev,
  input logic              rx_ovf_ev,
  input logic              irq_o,
  input logic [CNT_W-1:0]  rx_cnt,
  input logic              tx_urun,
  input logic              rx_ovf,
  input logic [7:0]        mask_q
);
  wire rx_wr  = reg_wr && (reg_addr == ADDR_W'('h194));
  wire msk_wr = reg_wr && (reg_addr == ADDR_W'('h198));

  AST_URUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_urun_ev |=> tx_urun); // R4
  AST_RX_CNT_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rcvd_ev && !(rx_wr && reg_wdata[0]) && rx_cnt != '1) |=> rx_cnt == $past(rx_cnt) + 1'b1); // R5
  AST_RX_CNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_rcvd_ev && rx_wr && reg_wdata[0] && rx_cnt != '0) |=> rx_cnt == $past(rx_cnt) - 1'b1); // R6
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovf_ev && rx_wr && reg_wdata[2]) |=> rx_ovf); // R7
  AST_MASK_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q & 8'h24) == 8'h00); // R8
  AST_MASK_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_wr && reg_wdata[7:0] == 8'h00) |=> !irq_o); // R10
endmodule

bind dma_evt_irq dma_evt_irq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .tx_urun_ev(tx_urun_ev), .rx_rcvd_ev(rx_rcvd_ev),
  .rx_ovf_ev(rx_ovf_ev), .irq_o(irq_o), .rx_cnt(rx_cnt), .tx_urun(tx_urun),
  .rx_ovf(rx_ovf), .mask_q(mask_q)
);

// File: tb/dma_evt_irq_tb.sv
`timescale 1ns/1ps
module dma_evt_irq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [5:0]  ev = '0;
  logic        irq_o;

  always #2.5 clk = ~clk;

  dma_evt_irq u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_sent_ev(ev[0]), .tx_urun_ev(ev[1]), .tx_berr_ev(ev[2]),
    .rx_rcvd_ev(ev[3]), .rx_ovf_ev(ev[4]), .rx_berr_ev(ev[5]),
    .irq_o(irq_o)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  int m_txc, m_rxc;
  bit m_tu, m_tb, m_ro, m_rb;
  logic [7:0] m_msk;

  function automatic int cnt_next(int c, bit ack, bit e);
    int n = c;
    if (ack && n > 0) n--;
    if (e && n < 255) n++;
    return n;
  endfunction

  function automatic logic [7:0] m_sum();
    logic [7:0] v;
    v = '0;
    v[0] = (m_txc != 0); v[1] = m_tu; v[3] = m_tb;
    v[4] = (m_rxc != 0); v[6] = m_ro; v[7] = m_rb;
    return v & m_msk;
  endfunction

  function automatic logic [31:0] exp_rd(logic [11:0] a);
    logic [31:0] r;
    r = '0;
    case (a)
      12'h188: begin r[0] = (m_txc != 0); r[1] = m_tu; r[3] = m_tb; r[23:16] = 8'(m_txc); end
      12'h194: begin r[0] = (m_rxc != 0); r[2] = m_ro; r[3] = m_rb; r[23:16] = 8'(m_rxc); end
      12'h198: r[7:0] = m_msk;
      12'h19C: r[7:0] = m_sum();
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic check_all(string tag);
    logic [11:0] addrs [5];
    string reqs [5];
    addrs = '{12'h188, 12'h194, 12'h198, 12'h19C, 12'h180};
    reqs  = '{"R2", "R3", "R8", "R9", "R11"};
    for (int i = 0; i < 5; i++) begin
      reg_addr = addrs[i];
      #0.2;
      chk({tag, "/", reqs[i]}, reg_rdata, exp_rd(addrs[i]));
    end
    #0.1;
    chk({tag, "/R10 irq"}, {31'd0, irq_o}, {31'd0, (m_sum() != 0)});
  endtask

  task automatic step(string tag, logic [5:0] e, bit w, logic [11:0] a, logic [31:0] d);
    bit wt, wr_r;
    @(negedge clk);
    ev = e; reg_wr = w; reg_addr = a; reg_wdata = d;
    wt = w && a == 12'h188;
    wr_r = w && a == 12'h194;
    m_txc = cnt_next(m_txc, wt && d[0], e[0]);
    m_rxc = cnt_next(m_rxc, wr_r && d[0], e[3]);
    m_tu = e[1] | (m_tu & !(wt && d[1]));
    m_tb = e[2] | (m_tb & !(wt && d[3]));
    m_ro = e[4] | (m_ro & !(wr_r && d[2]));
    m_rb = e[5] | (m_rb & !(wr_r && d[3]));
    if (w && a == 12'h198) m_msk = d[7:0] & 8'hDB;
    @(posedge clk);
    #1;
    ev = '0; reg_wr = 1'b0;
    check_all(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [11:0] pick [6];
    pick = '{12'h188, 12'h194, 12'h198, 12'h19C, 12'h180, 12'h000};
    void'($urandom(32'd1234));
    m_txc = 0; m_rxc = 0; m_tu = 0; m_tb = 0; m_ro = 0; m_rb = 0; m_msk = '0;
    #12;
    check_all("R1");
    chk("R1 irq", {31'd0, irq_o}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // R4: sticky flags, write-0 ignored, write-1 clears
    step("R4", 6'b110110, 1'b0, 12'h0, 32'h0);
    step("R4", 6'b0, 1'b1, 12'h188, 32'h0);
    step("R4", 6'b0, 1'b1, 12'h194, 32'h0);
    step("R4", 6'b0, 1'b1, 12'h188, 32'h0000_0002);
    step("R4", 6'b0, 1'b1, 12'h194, 32'h0000_000C);
    // R8/R10: enable all, then disable all
    step("R8", 6'b0, 1'b1, 12'h198, 32'hFFFF_FFFF);
    step("R10", 6'b0, 1'b1, 12'h198, 32'h0);
    step("R10", 6'b0, 1'b1, 12'h198, 32'h0000_00DB);
    // R9: writes to summary ignored; R11: unmapped write ignored
    step("R9", 6'b0, 1'b1, 12'h19C, 32'hFFFF_FFFF);
    step("R11", 6'b0, 1'b1, 12'h180, 32'hFFFF_FFFF);
    // R5: saturate receive count at 255
    for (int i = 0; i < 260; i++) step("R5", 6'b001000, 1'b0, 12'h0, 32'h0);
    // R7: strobe and ack together at saturation keep 255
    step("R7", 6'b001000, 1'b1, 12'h194, 32'h1);
    // R6: drain to zero, then ack at zero
    for (int i = 0; i < 256; i++) step("R6", 6'b0, 1'b1, 12'h194, 32'h1);
    step("R6", 6'b0, 1'b1, 12'h188, 32'h1);
    // R7: collisions on flags and counts
    step("R7", 6'b010001, 1'b1, 12'h194, 32'h4);
    step("R7", 6'b000011, 1'b1, 12'h188, 32'h3);
    step("R7", 6'b001000, 1'b1, 12'h194, 32'h5);

    for (int i = 0; i < 3000; i++) begin
      logic [5:0] e;
      logic [31:0] d;
      e = '0;
      for (int k = 0; k < 6; k++) e[k] = ($urandom_range(0, 3) == 0);
      d = $urandom;
      if ($urandom_range(0, 1) == 0) d[31:8] = '0;
      step("RND", e, $urandom_range(0, 2) != 0, pick[$urandom_range(0, 5)], d);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule